// File: doc/BRIEF.md
# Branch Target Table with Two-Bit Direction Predictors

This block sits beside an instruction fetch stage and guesses, one cycle ahead of decode, where fetch should go next. It is a small fully associative table of eight entries. Each entry pairs the address of a branch instruction with the last target seen for it and a two-bit direction predictor. A fetch-side lookup port presents a program counter and, in the same cycle, gets back whether the address is a known branch, the predicted direction, the stored target and the resulting next fetch address. On a miss, or a predicted not-taken hit, that address is the sequential one (`pc + 1`). On a predicted-taken hit, it is the stored target.

An execute-side resolution port reports each resolved branch with its address, real direction and real target. In the same cycle the block compares what it would have predicted with what happened and raises a mispredict flag. At the next clock edge it trains the table. A branch already in the table moves its predictor one step toward the real outcome. A branch not yet in the table is written into an empty slot, or, when all slots are full, into the slot whose branch was resolved least recently.

Internally, each resolution is classified as one of three actions:
- `ACT_IDLE`: no resolution this cycle.
- `ACT_UPDATE`: the branch is already in the table.
- `ACT_ALLOC`: a new entry is written.

Each entry's predictor is a four-state machine:
- `CTR_STRONG_NT` (00)
- `CTR_WEAK_NT` (01)
- `CTR_WEAK_T` (10)
- `CTR_STRONG_T` (11)

A taken outcome moves the predictor one step toward `CTR_STRONG_T`, and a not-taken outcome moves it one step toward `CTR_STRONG_NT`. Both ends saturate.

Top module: `branch_history_table`

## Requirements
- R1: After reset no entry is valid: every lookup reports `lk_hit`=0 and `lk_next_pc` = `lk_pc`+1 (modulo 2^ADDR_W), and a first resolution of any address is treated as a miss.
- R2: On a lookup miss, or while `lk_valid`=0, `lk_hit`=0, `lk_taken`=0, `lk_target`=0 and `lk_next_pc` = `lk_pc`+1.
- R3: On a lookup hit, `lk_target` is the entry's stored target. `lk_taken` is 1 exactly when the predictor state is 10 or 11. `lk_next_pc` is the stored target when `lk_taken`=1 and `lk_pc`+1 otherwise.
- R4: A resolution that misses the table writes a new entry holding `rs_pc` and `rs_target`. The predictor starts in state 10 if `rs_taken`=1 and in state 01 if not. The entry hits from the following cycle on.
- R5: A resolution that hits moves the predictor one step toward 11 if taken and one step toward 00 if not taken, saturating at both ends. From a strong state (11 or 00) the predicted direction flips only after two opposite outcomes in a row; an agreeing outcome in between restores the strong state.
- R6: A taken resolution that hits replaces the stored target with `rs_target`. A not-taken resolution that hits leaves the stored target unchanged.
- R7: `rs_mispredict` is combinational in the cycle `rs_valid`=1. It is 1 exactly when the predicted next address differs from the actual next address. The predicted next address is the stored target if the entry hits in state 10 or 11, and `rs_pc`+1 otherwise. The actual next address is `rs_target` if `rs_taken`=1, and `rs_pc`+1 otherwise. The flag is 0 while `rs_valid`=0.
- R8: While an empty slot remains, a new branch fills the lowest-numbered empty slot, and no existing entry is displaced.
- R9: When all slots are full, a new branch replaces the entry whose most recent resolution (allocation or update) is oldest. Resolving an existing entry makes it the most recent.
- R10: A lookup and a resolution of the same address in the same cycle return the entry's contents from before that resolution. The change is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_pc | input | ADDR_W | Address being fetched |
| lk_hit | output | 1 | Address found in table |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Stored target of the hit entry, 0 on miss |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | ADDR_W | Actual target address |
| rs_mispredict | output | 1 | Prediction for the resolved branch was wrong |

## Verification
A predictor state machine that steps wrongly stays hidden until the predicted direction crosses the 01/10 boundary. The bench therefore walks one entry through every state, probing with a lookup after each resolution. A one-step error then shows as a wrong `lk_taken` or `rs_mispredict` within one cycle of the faulty edge. A wrong replacement age shows only when the table is full and a new branch evicts the wrong entry. That is why the replacement test fills all slots, refreshes the oldest entry and checks which entry vanished on the next lookup. A stale target shows directly on `lk_target` and `lk_next_pc` in the cycle after the resolution that should have replaced it.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'b00,
        ACT_UPDATE = 2'b01,
        ACT_ALLOC  = 2'b10
    } rs_action_e;

    // One saturating step toward the observed outcome.
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_state_e s);
        return (s == CTR_WEAK_T) || (s == CTR_STRONG_T);
    endfunction

    function automatic ctr_state_e ctr_initial(input logic taken);
        return taken ? CTR_WEAK_T : CTR_WEAK_NT;
    endfunction

endpackage

// File: rtl/bht_entry.sv
module bht_entry
    import bht_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              update_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_target,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_tag,
    output logic [ADDR_W-1:0] ent_target,
    output ctr_state_e        ent_state
);

    logic              valid_q, valid_d;
    logic [ADDR_W-1:0] tag_q, tag_d;
    logic [ADDR_W-1:0] target_q, target_d;
    ctr_state_e        state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            tag_q    <= '0;
            target_q <= '0;
            state_q  <= CTR_WEAK_NT;
        end else begin
            valid_q  <= valid_d;
            tag_q    <= tag_d;
            target_q <= target_d;
            state_q  <= state_d;
        end
    end

    // Next state
    always_comb begin
        valid_d  = valid_q;
        tag_d    = tag_q;
        target_d = target_q;
        state_d  = state_q;
        if (alloc_en) begin
            valid_d  = 1'b1;
            tag_d    = wr_pc;
            target_d = wr_target;
            state_d  = ctr_initial(wr_taken);
        end else if (update_en) begin
            state_d = ctr_next(state_q, wr_taken);
            if (wr_taken) begin
                target_d = wr_target;
            end
        end
    end

    // Outputs
    always_comb begin
        ent_valid  = valid_q;
        ent_tag    = tag_q;
        ent_target = target_q;
        ent_state  = state_q;
    end

endmodule

// File: rtl/bht_match.sv
module bht_match #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]              key,
    input  logic [ENTRIES-1:0]             valid_vec,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec,
    output logic [ENTRIES-1:0]             match_vec,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (tag_vec[g] == key);
    end

    assign hit = |match_vec;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bht_lru.sv
module bht_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              touched_age;

    assign touched_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found_empty;
        found_empty = 1'b0;
        victim_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                victim_idx  = IDX_W'(i);
                found_empty = 1'b1;
            end
        end
        if (!found_empty) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == OLDEST) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/branch_history_table.sv
module branch_history_table
    import bht_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target,
    output logic              rs_mispredict
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_target;
    ctr_state_e                     ent_state [ENTRIES];

    logic [ENTRIES-1:0] lk_match;
    logic               lk_m_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] rs_match;
    logic               rs_hit;
    logic [IDX_W-1:0]   rs_idx;

    logic [IDX_W-1:0]   victim_idx;
    rs_action_e         action;
    logic [ENTRIES-1:0] alloc_vec;
    logic [ENTRIES-1:0] update_vec;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    logic [ADDR_W-1:0]  rs_seq_pc;
    logic [ADDR_W-1:0]  rs_pred_next;
    logic [ADDR_W-1:0]  rs_actual_next;

    bht_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_match (
        .key       (lk_pc),
        .valid_vec (ent_valid),
        .tag_vec   (ent_tag),
        .match_vec (lk_match),
        .hit       (lk_m_hit),
        .idx       (lk_idx)
    );

    bht_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rs_match (
        .key       (rs_pc),
        .valid_vec (ent_valid),
        .tag_vec   (ent_tag),
        .match_vec (rs_match),
        .hit       (rs_hit),
        .idx       (rs_idx)
    );

    bht_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (ent_valid),
        .victim_idx (victim_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        bht_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_vec[g]),
            .update_en  (update_vec[g]),
            .wr_pc      (rs_pc),
            .wr_taken   (rs_taken),
            .wr_target  (rs_target),
            .ent_valid  (ent_valid[g]),
            .ent_tag    (ent_tag[g]),
            .ent_target (ent_target[g]),
            .ent_state  (ent_state[g])
        );
    end

    // Fetch-side lookup, reads registered contents only.
    always_comb begin
        lk_hit    = lk_valid && lk_m_hit;
        lk_taken  = lk_hit && ctr_says_taken(ent_state[lk_idx]);
        lk_target = lk_hit ? ent_target[lk_idx] : '0;
        lk_next_pc = lk_taken ? lk_target : lk_pc + 1'b1;
    end

    // Resolution action selection.
    always_comb begin
        if (!rs_valid) begin
            action = ACT_IDLE;
        end else if (rs_hit) begin
            action = ACT_UPDATE;
        end else begin
            action = ACT_ALLOC;
        end
    end

    always_comb begin
        alloc_vec  = '0;
        update_vec = '0;
        touch_en   = 1'b0;
        touch_idx  = '0;
        unique case (action)
            ACT_IDLE: begin
            end
            ACT_UPDATE: begin
                update_vec[rs_idx] = 1'b1;
                touch_en           = 1'b1;
                touch_idx          = rs_idx;
            end
            ACT_ALLOC: begin
                alloc_vec[victim_idx] = 1'b1;
                touch_en              = 1'b1;
                touch_idx             = victim_idx;
            end
            default: begin
            end
        endcase
    end

    // Mispredict detection against pre-update contents.
    always_comb begin
        rs_seq_pc      = rs_pc + 1'b1;
        rs_pred_next   = (rs_hit && ctr_says_taken(ent_state[rs_idx])) ? ent_target[rs_idx] : rs_seq_pc;
        rs_actual_next = rs_taken ? rs_target : rs_seq_pc;
        rs_mispredict  = rs_valid && (rs_pred_next != rs_actual_next);
    end

endmodule

// File: rtl/branch_history_table_checks.sv
module branch_history_table_checks #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [ADDR_W-1:0]  lk_pc,
    input logic               lk_hit,
    input logic               lk_taken,
    input logic [ADDR_W-1:0]  lk_target,
    input logic [ADDR_W-1:0]  lk_next_pc,
    input logic               rs_valid,
    input logic [ADDR_W-1:0]  rs_pc,
    input logic               rs_taken,
    input logic               rs_hit,
    input logic               rs_mispredict,
    input logic [ENTRIES-1:0] lk_match
);

    // R2: sequential address on a miss
    a_r2_miss_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_next_pc == lk_pc + 1'b1));

    // R2: no hit without a request
    a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R3: a taken prediction steers to the stored target
    a_r3_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_taken) |-> (lk_next_pc == lk_target));

    // R3: an address matches at most one entry
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R4: a resolved branch is present one cycle later
    a_r4_resolved_hits: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rs_valid) && lk_valid && (lk_pc == $past(rs_pc))) |-> lk_hit);

    // R7: no flag without a resolution
    a_r7_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !rs_mispredict);

    // R7: a not-taken branch absent from the table was predicted correctly
    a_r7_nt_miss_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit && !rs_taken) |-> !rs_mispredict);

endmodule

bind branch_history_table branch_history_table_checks #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_pc         (lk_pc),
    .lk_hit        (lk_hit),
    .lk_taken      (lk_taken),
    .lk_target     (lk_target),
    .lk_next_pc    (lk_next_pc),
    .rs_valid      (rs_valid),
    .rs_pc         (rs_pc),
    .rs_taken      (rs_taken),
    .rs_hit        (rs_hit),
    .rs_mispredict (rs_mispredict),
    .lk_match      (lk_match)
);

// File: tb/branch_history_table_bench.sv
module branch_history_table_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic          lk_hit;
    logic          lk_taken;
    logic [AW-1:0] lk_target;
    logic [AW-1:0] lk_next_pc;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_pc = '0;
    logic          rs_taken = 1'b0;
    logic [AW-1:0] rs_target = '0;
    logic          rs_mispredict;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    branch_history_table #(.ENTRIES(8), .ADDR_W(AW)) u_branch_history_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_pc         (lk_pc),
        .lk_hit        (lk_hit),
        .lk_taken      (lk_taken),
        .lk_target     (lk_target),
        .lk_next_pc    (lk_next_pc),
        .rs_valid      (rs_valid),
        .rs_pc         (rs_pc),
        .rs_taken      (rs_taken),
        .rs_target     (rs_target),
        .rs_mispredict (rs_mispredict)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        lk_valid = 1'b0;
        rs_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Combinational lookup probe, no clock edge consumed.
    task automatic look(input logic [AW-1:0] pc, input bit e_hit, input bit e_taken,
                        input logic [AW-1:0] e_tgt, input logic [AW-1:0] e_next,
                        input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_pc    = pc;
        #1;
        chk(lk_hit == e_hit,         req, "lk_hit",     32'(lk_hit),     32'(e_hit));
        chk(lk_taken == e_taken,     req, "lk_taken",   32'(lk_taken),   32'(e_taken));
        chk(lk_target == e_tgt,      req, "lk_target",  32'(lk_target),  32'(e_tgt));
        chk(lk_next_pc == e_next,    req, "lk_next_pc", 32'(lk_next_pc), 32'(e_next));
        lk_valid = 1'b0;
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input bit taken,
                           input logic [AW-1:0] tgt, input bit e_mis, input string req);
        @(negedge clk);
        rs_valid  = 1'b1;
        rs_pc     = pc;
        rs_taken  = taken;
        rs_target = tgt;
        #1;
        chk(rs_mispredict == e_mis, req, "rs_mispredict", 32'(rs_mispredict), 32'(e_mis));
        @(posedge clk);
        #1;
        rs_valid = 1'b0;
    endtask

    localparam logic [AW-1:0] PA = 16'h0040, TA = 16'h0200, TA2 = 16'h0A00, TA3 = 16'h0B00;
    localparam logic [AW-1:0] PB = 16'h0050, TB = 16'h0300;

    task automatic t_reset();
        look(16'h0100, 0, 0, 16'h0000, 16'h0101, "R1");
        look(16'hFFFF, 0, 0, 16'h0000, 16'h0000, "R1");
        @(negedge clk);
        lk_valid = 1'b0;
        lk_pc    = 16'h0123;
        #1;
        chk(lk_hit == 1'b0, "R2", "idle lk_hit", 32'(lk_hit), 0);
        chk(lk_next_pc == 16'h0124, "R2", "idle lk_next_pc", 32'(lk_next_pc), 32'h124);
    endtask

    task automatic t_alloc();
        resolve(PA, 1, TA, 1, "R7");
        look(PA, 1, 1, TA, TA, "R4");
        resolve(PB, 0, TB, 0, "R7");
        look(PB, 1, 0, TB, PB + 1'b1, "R4");
        resolve(16'h0060, 1, 16'h0061, 0, "R7");
        look(16'h0060, 1, 1, 16'h0061, 16'h0061, "R4");
        look(16'h0070, 0, 0, 16'h0000, 16'h0071, "R2");
    endtask

    task automatic t_counter();
        // PA starts weak taken.
        resolve(PA, 0, 16'h0999, 1, "R7");
        look(PA, 1, 0, TA, PA + 1'b1, "R6");
        resolve(PA, 1, TA, 1, "R5");
        look(PA, 1, 1, TA, TA, "R5");
        resolve(PA, 1, TA, 0, "R5");
        resolve(PA, 0, TA, 1, "R5");
        look(PA, 1, 1, TA, TA, "R5");
        resolve(PA, 1, TA, 0, "R5");
        resolve(PA, 0, TA, 1, "R5");
        look(PA, 1, 1, TA, TA, "R5");
        resolve(PA, 0, TA, 1, "R5");
        look(PA, 1, 0, TA, PA + 1'b1, "R5");
        resolve(PA, 0, TA, 0, "R5");
        resolve(PA, 1, TA2, 1, "R5");
        look(PA, 1, 0, TA2, PA + 1'b1, "R6");
        resolve(PA, 1, TA2, 1, "R5");
        look(PA, 1, 1, TA2, TA2, "R5");
        resolve(PA, 1, TA3, 1, "R7");
        look(PA, 1, 1, TA3, TA3, "R6");
    endtask

    task automatic t_same_cycle();
        // PB sits at weak not-taken with target TB.
        @(negedge clk);
        lk_valid  = 1'b1;
        lk_pc     = PB;
        rs_valid  = 1'b1;
        rs_pc     = PB;
        rs_taken  = 1'b1;
        rs_target = TB;
        #1;
        chk(lk_hit == 1'b1,   "R10", "lk_hit same cycle",   32'(lk_hit), 1);
        chk(lk_taken == 1'b0, "R10", "lk_taken same cycle", 32'(lk_taken), 0);
        chk(lk_next_pc == PB + 1'b1, "R10", "lk_next_pc same cycle", 32'(lk_next_pc), 32'(PB + 1'b1));
        chk(rs_mispredict == 1'b1, "R7", "rs_mispredict same cycle", 32'(rs_mispredict), 1);
        @(posedge clk);
        #1;
        rs_valid = 1'b0;
        chk(lk_taken == 1'b1, "R10", "lk_taken after edge", 32'(lk_taken), 1);
        chk(lk_next_pc == TB, "R10", "lk_next_pc after edge", 32'(lk_next_pc), 32'(TB));
        lk_valid = 1'b0;
    endtask

    task automatic t_lru();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            resolve(AW'(16'h1000 + i * 16), 1, AW'(16'h2000 + i), 1, "R8");
        end
        for (int i = 0; i < 8; i++) begin
            look(AW'(16'h1000 + i * 16), 1, 1, AW'(16'h2000 + i), AW'(16'h2000 + i), "R8");
        end
        resolve(16'h1000, 1, 16'h2000, 0, "R9");
        resolve(16'h1080, 1, 16'h2008, 1, "R9");
        look(16'h1010, 0, 0, 16'h0000, 16'h1011, "R9");
        look(16'h1000, 1, 1, 16'h2000, 16'h2000, "R9");
        look(16'h1080, 1, 1, 16'h2008, 16'h2008, "R9");
        look(16'h1020, 1, 1, 16'h2002, 16'h2002, "R9");
        resolve(16'h1090, 0, 16'h2009, 0, "R9");
        look(16'h1020, 0, 0, 16'h0000, 16'h1021, "R9");
        look(16'h1030, 1, 1, 16'h2003, 16'h2003, "R9");
        look(16'h1090, 1, 0, 16'h2009, 16'h1091, "R4");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_alloc();
        t_counter();
        t_same_cycle();
        t_lru();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule